// File: doc/BRIEF.md
# Multi-Channel Copy Interrupt Controller

This block gathers the interrupt sources of several copy channels onto one shared interrupt line. Each channel has a four-bit status register. Its bits latch a copy-done pulse, a ring high-watermark crossing, a ring low-watermark crossing and an error pulse. Software clears status bits by writing ones to them. A per-channel enable register gates the copy-done and watermark bits. A second per-channel enable register gates the error bit.

Each channel's ring fill level is compared against a programmable high and low threshold. Both thresholds sit in one register. A crossing latches once and does not fire again until the level has returned inside the threshold. A read-only summary word holds one bit per channel, so a handler on the shared line can find the channels that need service.

Register addressing: `reg_addr[1:0]` selects the register, `reg_addr[CH_W+1:2]` selects the channel, and the top address bit selects the summary word. Reads are combinational.

Top module: `copy_irq_ctrl`

## Requirements
- R1: After reset every status bit, copy/watermark enable and error enable is 0, the high threshold is all ones, the low threshold is 0, the summary reads 0 and `irq_o` is low.
- R2: A pulse on `cc_evt[c]` sets status bit 0 of channel c, and a pulse on `err_evt[c]` sets status bit 3. Status (select 0) reads back with bit 0 copy-done, bit 1 high watermark, bit 2 low watermark and bit 3 error.
- R3: A write to select 0 clears exactly the status bits that are 1 in `reg_wdata[3:0]`. Bits written as 0 are unchanged.
- R4: A status bit whose event arrives in the same cycle as a clear of that bit is set after that cycle.
- R5: Select 1 holds the enables: bit 0 for copy-done, bit 1 for high watermark, bit 2 for low watermark. Select 2 bit 0 enables the error bit. Both registers read back as written.
- R6: Summary bit c is the OR of channel c's status bits ANDed with their enables. It reads at any address whose top bit is 1, and writes to that address change nothing. `irq_o` is the OR of all summary bits.
- R7: Select 3 holds the low threshold in bits [LVL_W-1:0] and the high threshold in bits [2*LVL_W-1:LVL_W]. It reads back as written.
- R8: Status bit 1 is set one cycle after the fill level becomes strictly greater than the high threshold. It is not set again while the level stays above the threshold, even after being cleared.
- R9: Status bit 2 is set one cycle after the fill level becomes strictly less than the low threshold. It does not fire again until the level has returned to or above it.
- R10: Events, clears and register writes for one channel leave every other channel's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_evt | input | NCH | Copy-done pulse, one per channel |
| err_evt | input | NCH | Error pulse, one per channel |
| fill_lvl | input | NCH*LVL_W | Ring occupancy, LVL_W bits per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | CH_W+3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| irq_o | output | 1 | Shared interrupt line |

## Verification
The bench targets four situations:
- An event in the same cycle as a clear of its bit. A design that lets the clear win would lose that interrupt.
- A clear mask with zero bits. A design that clears the whole register would drop pending events on other bits.
- A watermark level that stays above its threshold after its bit is cleared. A design that detects level rather than crossing would re-fire at once and cause an interrupt storm.
- Error bits without their separate enable, and copy-done bits on other channels. A design that decodes enables or channels wrongly would raise `irq_o` or set summary bits for channels that have nothing enabled.

// File: rtl/copy_irq_ctrl.sv
module copy_irq_ctrl #(
  parameter int NCH   = 4,
  parameter int LVL_W = 8,
  parameter int DW    = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW   = CH_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       cc_evt,
  input  logic [NCH-1:0]       err_evt,
  input  logic [NCH*LVL_W-1:0] fill_lvl,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 irq_o
);

  logic [3:0]       stat_q [NCH];
  logic [2:0]       en_q   [NCH];
  logic [LVL_W-1:0] hi_q   [NCH];
  logic [LVL_W-1:0] lo_q   [NCH];
  logic [NCH-1:0]   men_q, above_q, below_q;
  logic [NCH-1:0]   above_now, below_now, hit, summary;
  logic [3:0]       set_v  [NCH];
  logic [3:0]       clr_v  [NCH];
  logic [NCH*4-1:0] status_flat;

  wire [1:0]      sel  = reg_addr[1:0];
  wire [CH_W-1:0] ach  = reg_addr[CH_W+1:2];
  wire            glob = reg_addr[AW-1];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      above_now[c] = fill_lvl[c*LVL_W +: LVL_W] > hi_q[c];
      below_now[c] = fill_lvl[c*LVL_W +: LVL_W] < lo_q[c];
      hit[c]       = reg_we && !glob && (ach == CH_W'(c));
      clr_v[c]     = (hit[c] && sel == 2'd0) ? reg_wdata[3:0] : 4'd0;
      set_v[c]     = {err_evt[c], below_now[c] & ~below_q[c],
                      above_now[c] & ~above_q[c], cc_evt[c]};
      summary[c]   = |(stat_q[c] & {men_q[c], en_q[c]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q   <= '0;
      above_q <= '0;
      below_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        stat_q[c] <= '0;
        en_q[c]   <= '0;
        hi_q[c]   <= '1;
        lo_q[c]   <= '0;
      end
    end else begin
      above_q <= above_now;
      below_q <= below_now;
      for (int c = 0; c < NCH; c++) begin
        stat_q[c] <= (stat_q[c] & ~clr_v[c]) | set_v[c];
        if (hit[c]) begin
          case (sel)
            2'd1: en_q[c] <= reg_wdata[2:0];
            2'd2: men_q[c] <= reg_wdata[0];
            2'd3: begin
              lo_q[c] <= reg_wdata[LVL_W-1:0];
              hi_q[c] <= reg_wdata[2*LVL_W-1:LVL_W];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (glob) begin
      reg_rdata[NCH-1:0] = summary;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (ach == CH_W'(c)) begin
          case (sel)
            2'd0: reg_rdata[3:0] = stat_q[c];
            2'd1: reg_rdata[2:0] = en_q[c];
            2'd2: reg_rdata[0]   = men_q[c];
            default: reg_rdata[2*LVL_W-1:0] = {hi_q[c], lo_q[c]};
          endcase
        end
      end
    end
  end

  always_comb
    for (int c = 0; c < NCH; c++) status_flat[c*4 +: 4] = stat_q[c];

  assign irq_o = |summary;

endmodule

// File: rtl/copy_irq_ctrl_chk.sv
module copy_irq_ctrl_chk #(
  parameter int NCH  = 4,
  parameter int DW   = 32,
  parameter int CH_W = 2,
  parameter int AW   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   cc_evt,
  input logic [NCH-1:0]   err_evt,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [NCH*4-1:0] status_flat,
  input logic             irq_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire clr0 = reg_we && !reg_addr[AW-1] && reg_addr[AW-2:2] == CH_W'(c)
                && reg_addr[1:0] == 2'd0 && reg_wdata[0];

    a_r2_cc_sets: assert property (@(posedge clk) disable iff (!rst_n)
      cc_evt[c] |=> status_flat[c*4]);

    a_r4_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt[c] |=> status_flat[c*4+3]);

    a_r3_clear_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      (clr0 && !cc_evt[c]) |=> !status_flat[c*4]);

    a_r3_hold_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      (status_flat[c*4] && !clr0) |=> status_flat[c*4]);
  end

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flat == '0) |-> !irq_o);

endmodule

bind copy_irq_ctrl copy_irq_ctrl_chk #(.NCH(NCH), .DW(DW), .CH_W(CH_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cc_evt(cc_evt), .err_evt(err_evt),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .status_flat(status_flat), .irq_o(irq_o));

// File: tb/sim_copy_irq_ctrl.sv
module sim_copy_irq_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  cc_evt = 0, err_evt = 0;
  logic [31:0] fill_lvl = 0;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  copy_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .cc_evt(cc_evt), .err_evt(err_evt),
    .fill_lvl(fill_lvl), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o));

  // {ch[31:30], cc[29], err[28], we[27], sel[26:25], wdata[24:9], exp_stat[8:5], exp_irq[4], exp_sum[3:0]}
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0000, 4'b0001, 1'b0, 4'b0000},
    {2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0001, 4'b0001, 1'b1, 4'b0001},
    {2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0000, 4'b1000, 1'b1, 4'b0001},
    {2'd1, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0001, 4'b1000, 1'b1, 4'b0011},
    {2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0000, 4'b0001, 1'b1, 4'b0011},
    {2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0001, 4'b0000, 1'b1, 4'b0010},
    {2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 16'h0008, 4'b1000, 1'b1, 4'b0010},
    {2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0008, 4'b0000, 1'b0, 4'b0000},
    {2'd2, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0000, 4'b1001, 1'b0, 4'b0000},
    {2'd2, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0001, 4'b1001, 1'b1, 4'b0100},
    {2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0001, 4'b1000, 1'b0, 4'b0000},
    {2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0008, 4'b0000, 1'b0, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = {1'b0, ch, sel}; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic setlvl(input int ch, input logic [7:0] v);
    @(negedge clk);
    fill_lvl[ch*8 +: 8] = v;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd({1'b0, 2'(c), 2'd0}, d); chk("R1 status", d, 0);
      rd({1'b0, 2'(c), 2'd3}, d); chk("R1 thresholds", d, 32'h0000FF00);
    end
    rd(5'b10000, d); chk("R1 summary", d, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);

    // R2 R3 R4 R5 R6 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      @(negedge clk);
      cc_evt = 4'(v[29]) << v[31:30];
      err_evt = 4'(v[28]) << v[31:30];
      reg_we = v[27];
      reg_addr = {1'b0, v[31:30], v[26:25]};
      reg_wdata = {16'd0, v[24:9]};
      @(negedge clk);
      cc_evt = 0; err_evt = 0; reg_we = 0;
      rd({1'b0, v[31:30], 2'd0}, d); chk("R2/R3/R4 status", d, {28'd0, v[8:5]});
      rd(5'b10000, d); chk("R6 summary", d, {28'd0, v[3:0]});
      chk("R6 irq", {31'd0, irq_o}, {31'd0, v[4]});
    end

    // R6 write to summary address ignored
    @(negedge clk); reg_we = 1; reg_addr = 5'b10000; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); reg_we = 0;
    rd(5'b10000, d); chk("R6 summary write ignored", d, 0);
    rd({1'b0, 2'd0, 2'd0}, d); chk("R6 summary write ignored status", d, 0);

    // R5 readback, R10 isolation
    wr(2'd3, 2'd1, 32'h6);
    rd({1'b0, 2'd3, 2'd1}, d); chk("R5 enable readback", d, 32'h6);
    rd({1'b0, 2'd2, 2'd1}, d); chk("R10 neighbour enable", d, 32'h1);
    rd({1'b0, 2'd1, 2'd2}, d); chk("R5 error enable readback", d, 32'h1);

    // R7 thresholds
    setlvl(3, 8'd5);
    wr(2'd3, 2'd3, 32'h0A03);
    rd({1'b0, 2'd3, 2'd3}, d); chk("R7 threshold readback", d, 32'h0A03);
    rd({1'b0, 2'd3, 2'd0}, d); chk("R8 inside band", d, 0);

    // R8 high crossing, no refire
    setlvl(3, 8'd10);
    rd({1'b0, 2'd3, 2'd0}, d); chk("R8 equal is not above", d, 0);
    setlvl(3, 8'd11);
    rd({1'b0, 2'd3, 2'd0}, d); chk("R8 high set", d, 32'h2);
    rd(5'b10000, d); chk("R8 summary", d, 32'h8);
    wr(2'd3, 2'd0, 32'h2);
    setlvl(3, 8'd12);
    rd({1'b0, 2'd3, 2'd0}, d); chk("R8 no refire", d, 0);
    chk("R8 irq low", {31'd0, irq_o}, 0);
    setlvl(3, 8'd5);
    setlvl(3, 8'd11);
    rd({1'b0, 2'd3, 2'd0}, d); chk("R8 refire after return", d, 32'h2);
    wr(2'd3, 2'd0, 32'h2);

    // R9 low crossing
    setlvl(3, 8'd2);
    rd({1'b0, 2'd3, 2'd0}, d); chk("R9 low set", d, 32'h4);
    chk("R9 irq", {31'd0, irq_o}, 1);
    wr(2'd3, 2'd0, 32'h4);
    setlvl(3, 8'd1);
    rd({1'b0, 2'd3, 2'd0}, d); chk("R9 no refire", d, 0);
    chk("R9 irq cleared", {31'd0, irq_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule